// File: doc/BRIEF.md
# Instruction Prefetch Buffer

This block sits between a 32-bit instruction fetch port and a decoder that handles a mix of 16-bit and 32-bit instructions. It sends out word-aligned fetch requests, one word each, and keeps up to three fetched words. From those words it builds the next complete instruction and offers it to the decoder through a valid/ready handshake.

A 32-bit instruction whose first halfword sits in the upper half of a word spans two fetched words. The block joins the two halves before it offers the instruction. Because the buffer keeps fetching ahead, only the first such instruction in a run has to wait for its second word. The instructions after it come out back to back.

A flush input redirects the stream. It empties the buffer and discards every response that is still in flight. Fetching then restarts at the word that holds the new target. If the target is halfword aligned, the low half of that first word is skipped.

Top module: `ifetch_align_buf`

## Requirements
- R1: Every fetch address has bits [1:0] equal to zero. After each accepted request (`fetch_req_o` and `fetch_ack_i` both high) the next request address is 4 higher. After a flush the next request goes to the target address with bits [1:0] cleared. No request is raised in a cycle where `flush_i` is high.
- R2: An instruction is 32-bit (`instr_is32_o` = 1) when bits [15:11] of its first halfword are 5'b11101, 5'b11110 or 5'b11111. Any other value marks a 16-bit instruction.
- R3: `instr_data_o[15:0]` holds the first halfword, taken from the lower memory address. For a 32-bit instruction, `instr_data_o[31:16]` holds the second halfword. For a 16-bit instruction, `instr_data_o[31:16]` is zero.
- R4: `instr_addr_o` is the halfword address of the offered instruction. It advances by 2 (16-bit) or 4 (32-bit) in the cycle after a handshake. While the output is valid and not accepted, the instruction, its size and its address stay unchanged.
- R5: A 32-bit instruction whose first halfword is at an address with bit 1 set is offered only when both of its words are in the buffer, and its value is the two halves joined together.
- R6: Conditions for this guarantee: the fetch port accepts every request, each response arrives in the cycle after acceptance, and the consumer is always ready. Under those conditions, in a run of consecutive 32-bit instructions that each start at an address with bit 1 set, every instruction after the first is accepted in the cycle right after the one before it.
- R7: In the cycle after `flush_i` is high, `instr_valid_o` is low. Responses to requests issued before the flush, including one arriving in the flush cycle, are discarded. The next instruction offered is the one at the target address (bit 0 of the target is ignored).
- R8: Words in flight (including those to be discarded) plus words held never exceed three. No request is raised while that sum, less any word being consumed in the same cycle, equals three.
- R9: During reset `instr_valid_o` is low. In the first cycle after reset a request is raised for the word at `RESET_ADDR` (bits [1:0] cleared), and the stream starts at `RESET_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Flush the buffer and redirect the stream |
| flush_addr_i | input | AW | Redirect target (halfword address) |
| fetch_req_o | output | 1 | Fetch request |
| fetch_addr_o | output | AW | Word-aligned fetch address |
| fetch_ack_i | input | 1 | Fetch port takes the request this cycle |
| rsp_valid_i | input | 1 | Fetch response word valid (responses return in request order) |
| rsp_data_i | input | 32 | Fetch response word |
| instr_valid_o | output | 1 | A complete instruction is offered |
| instr_ready_i | input | 1 | Decoder accepts the offered instruction |
| instr_data_o | output | 32 | Instruction value, first halfword in bits [15:0] |
| instr_is32_o | output | 1 | 1 for a 32-bit instruction |
| instr_addr_o | output | AW | Halfword address of the offered instruction |

## Verification
**Registered outputs.** The fetch address moves one cycle after an accepted request or a flush. The offered instruction changes one cycle after a handshake. A word returned in cycle t can complete an instruction no earlier than cycle t+1. Valid drops in the cycle right after a flush.

**How the bench samples.** The bench drives inputs just after the rising edge and samples every output at the falling edge. It compares each handshake seen there against a reference stream computed from the memory function and an expected address. The expected address is reset to the target in the flush cycle itself.

**Timing checks.**
- The back-to-back property is checked by requiring the handshake of each instruction in the run to land exactly one cycle after the previous one.
- The flush rule is checked at the first falling edge after the flush cycle.

// File: rtl/ifab_pkg.sv
`timescale 1ns/1ps
// Shared constants and the length decode for the prefetch buffer.
// Assumes halfword instructions whose length is fixed by the top five bits.
package ifab_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;

    // True when a first halfword opens a 32-bit instruction.
    function automatic logic is_wide(input logic [HALF_W-1:0] hw);
        return (hw[15:13] == 3'b111) && (hw[12:11] != 2'b00);
    endfunction
endpackage

// File: rtl/ifab_word_fifo.sv
`timescale 1ns/1ps
// Small circular word store with a peek at the two oldest entries.
// Assumes the caller never pushes when full nor pops when empty.
module ifab_word_fifo #(
    parameter int unsigned DEPTH = 3,
    parameter int unsigned DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         push_i,
    input  logic [DW-1:0]                data_i,
    input  logic                         pop_i,
    output logic [DW-1:0]                head_o,
    output logic [DW-1:0]                next_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] store_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    // Write the incoming word into its slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push_i && (wr_q == PW'(i))) store_q[i] <= data_i;
        end
    end

    // Track pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= wrap_inc(wr_q);
            if (pop_i)  rd_q <= wrap_inc(rd_q);
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
        end
    end

    // Expose the two oldest words and the level.
    always_comb begin
        head_o  = store_q[rd_q];
        next_o  = store_q[wrap_inc(rd_q)];
        count_o = cnt_q;
    end
endmodule

// File: rtl/ifab_fetch_ctrl.sv
`timescale 1ns/1ps
// Fetch side: issues word requests, counts words in flight and discards
// responses that belong to requests made before a flush.
// Assumes in-order responses, one word per request.
module ifab_fetch_ctrl #(
    parameter int unsigned AW         = 32,
    parameter int unsigned DEPTH      = 3,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush_i,
    input  logic [AW-1:0]               flush_addr_i,
    input  logic [$clog2(DEPTH+1)-1:0]  buf_cnt_i,
    input  logic                        pop_i,
    output logic                        fetch_req_o,
    output logic [AW-1:0]               fetch_addr_o,
    input  logic                        fetch_ack_i,
    input  logic                        rsp_valid_i,
    output logic                        push_o,
    output logic [$clog2(DEPTH+1)-1:0]  inflight_o
);
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam int unsigned SW = CW + 2;

    logic [AW-1:0] addr_q;
    logic [CW-1:0] live_q, drop_q;
    logic [SW-1:0] used;
    logic          take, rsp_drop;

    // Credit check and response routing.
    always_comb begin
        used        = SW'(buf_cnt_i) + SW'(live_q) + SW'(drop_q) - SW'(pop_i);
        fetch_req_o = !flush_i && (used < SW'(DEPTH));
        take        = fetch_req_o && fetch_ack_i;
        push_o      = rsp_valid_i && (drop_q == '0) && !flush_i;
        rsp_drop    = rsp_valid_i && (drop_q != '0);
        fetch_addr_o = addr_q;
        inflight_o   = live_q + drop_q;
    end

    // Address and in-flight counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= {RESET_ADDR[AW-1:2], 2'b00};
            live_q <= '0;
            drop_q <= '0;
        end else if (flush_i) begin
            addr_q <= {flush_addr_i[AW-1:2], 2'b00};
            live_q <= '0;
            drop_q <= live_q + drop_q - CW'(rsp_valid_i);
        end else begin
            if (take) addr_q <= addr_q + AW'(4);
            live_q <= live_q + CW'(take) - CW'(push_o);
            drop_q <= drop_q - CW'(rsp_drop);
        end
    end
endmodule

// File: rtl/ifab_align.sv
`timescale 1ns/1ps
// Builds the next instruction from the two oldest buffered words.
// Assumes half_sel_i marks a start in the upper half of the head word.
module ifab_align
    import ifab_pkg::*;
#(
    parameter int unsigned CW = 2
) (
    input  logic [WORD_W-1:0] head_i,
    input  logic [WORD_W-1:0] next_i,
    input  logic [CW-1:0]     cnt_i,
    input  logic              half_sel_i,
    output logic              valid_o,
    output logic              is32_o,
    output logic [WORD_W-1:0] data_o
);
    logic [HALF_W-1:0] first_hw;

    // Pick the first halfword, decode length, join halves.
    always_comb begin
        first_hw = half_sel_i ? head_i[31:16] : head_i[15:0];
        is32_o   = is_wide(first_hw);
        if (is32_o && half_sel_i) begin
            valid_o = cnt_i >= CW'(2);
            data_o  = {next_i[15:0], head_i[31:16]};
        end else if (is32_o) begin
            valid_o = cnt_i >= CW'(1);
            data_o  = head_i;
        end else begin
            valid_o = cnt_i >= CW'(1);
            data_o  = {{HALF_W{1'b0}}, first_hw};
        end
    end
endmodule

// File: rtl/ifetch_align_buf.sv
`timescale 1ns/1ps
// Three-word instruction prefetch buffer with halfword realignment.
// Fetches whole words ahead, hands out 16/32-bit instructions in order and
// restarts from a new target on flush. Assumes in-order fetch responses.
module ifetch_align_buf
    import ifab_pkg::*;
#(
    parameter int unsigned AW           = 32,
    parameter int unsigned DEPTH        = 3,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [AW-1:0]     flush_addr_i,
    output logic              fetch_req_o,
    output logic [AW-1:0]     fetch_addr_o,
    input  logic              fetch_ack_i,
    input  logic              rsp_valid_i,
    input  logic [31:0]       rsp_data_i,
    output logic              instr_valid_o,
    input  logic              instr_ready_i,
    output logic [31:0]       instr_data_o,
    output logic              instr_is32_o,
    output logic [AW-1:0]     instr_addr_o
);
    localparam int unsigned CW = $clog2(DEPTH+1);

    logic [WORD_W-1:0] head_w, next_w;
    logic [CW-1:0]     buf_cnt, inflight;
    logic              push, pop, accept;
    logic              half_q;
    logic [AW-1:0]     pc_q;

    ifab_word_fifo #(.DEPTH(DEPTH), .DW(WORD_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clr_i(flush_i),
        .push_i(push), .data_i(rsp_data_i), .pop_i(pop),
        .head_o(head_w), .next_o(next_w), .count_o(buf_cnt)
    );

    ifab_fetch_ctrl #(.AW(AW), .DEPTH(DEPTH), .RESET_ADDR(RESET_ADDR)) fetch_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
        .buf_cnt_i(buf_cnt), .pop_i(pop),
        .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_ack_i(fetch_ack_i),
        .rsp_valid_i(rsp_valid_i), .push_o(push), .inflight_o(inflight)
    );

    ifab_align #(.CW(CW)) align_i (
        .head_i(head_w), .next_i(next_w), .cnt_i(buf_cnt), .half_sel_i(half_q),
        .valid_o(instr_valid_o), .is32_o(instr_is32_o), .data_o(instr_data_o)
    );

    // Handshake and word retirement: a word leaves once its last half is used.
    always_comb begin
        accept       = instr_valid_o && instr_ready_i && !flush_i;
        pop          = accept && (half_q || instr_is32_o);
        instr_addr_o = pc_q;
    end

    // Stream address and half-word position within the head word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= {RESET_ADDR[AW-1:1], 1'b0};
            half_q <= RESET_ADDR[1];
        end else if (flush_i) begin
            pc_q   <= {flush_addr_i[AW-1:1], 1'b0};
            half_q <= flush_addr_i[1];
        end else if (accept) begin
            pc_q <= pc_q + (instr_is32_o ? AW'(4) : AW'(2));
            if (!instr_is32_o) half_q <= ~half_q;
        end
    end
endmodule

// File: rtl/ifetch_align_buf_chk.sv
`timescale 1ns/1ps
// Property checker for the prefetch buffer, attached by bind below.
module ifetch_align_buf_chk #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       flush_i,
    input logic                       fetch_req_o,
    input logic [AW-1:0]              fetch_addr_o,
    input logic                       fetch_ack_i,
    input logic                       instr_valid_o,
    input logic                       instr_ready_i,
    input logic [31:0]                instr_data_o,
    input logic                       instr_is32_o,
    input logic [AW-1:0]              instr_addr_o,
    input logic [$clog2(DEPTH+1):0]   occ_i
);
    localparam int unsigned OW = $clog2(DEPTH+1) + 1;

    // R1
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> (fetch_addr_o[1:0] == 2'b00));

    // R1
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_ack_i) |=> (fetch_addr_o == $past(fetch_addr_o) + AW'(4)));

    // R1
    no_req_on_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !fetch_req_o);

    // R2
    size_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_o |-> (instr_is32_o == (instr_data_o[15:11] >= 5'b11101)));

    // R3
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_o && !instr_is32_o) |-> (instr_data_o[31:16] == 16'h0000));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_o && !instr_ready_i && !flush_i) |=>
        (instr_valid_o && $stable(instr_data_o) && $stable(instr_addr_o) && $stable(instr_is32_o)));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_o && instr_ready_i && !flush_i) |=>
        (instr_addr_o == $past(instr_addr_o) + ($past(instr_is32_o) ? AW'(4) : AW'(2))));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !instr_valid_o);

    // R8
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_i <= OW'(DEPTH));
endmodule

bind ifetch_align_buf ifetch_align_buf_chk #(.AW(AW), .DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_ack_i(fetch_ack_i),
    .instr_valid_o(instr_valid_o), .instr_ready_i(instr_ready_i),
    .instr_data_o(instr_data_o), .instr_is32_o(instr_is32_o), .instr_addr_o(instr_addr_o),
    .occ_i({1'b0, buf_cnt} + {1'b0, inflight})
);

// File: tb/ifetch_align_buf_tb_top.sv
`timescale 1ns/1ps
module ifetch_align_buf_tb_top;
    localparam int unsigned AW = 32;
    localparam logic [31:0] RUN_BASE = 32'h0000_1002;
    localparam logic [31:0] RUN_END  = 32'h0000_10C0;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, flush_i, fetch_req_o, fetch_ack_i, rsp_valid_i;
    logic          instr_valid_o, instr_ready_i, instr_is32_o;
    logic [AW-1:0] flush_addr_i, fetch_addr_o, instr_addr_o;
    logic [31:0]   rsp_data_i, instr_data_o;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  fixed_lat = 1'b0;
    bit  run_chk = 1'b0;
    bit  done = 1'b0;
    logic [31:0] rq[$];

    ifetch_align_buf #(.AW(AW), .DEPTH(3), .RESET_ADDR('0)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
        .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_ack_i(fetch_ack_i),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
        .instr_valid_o(instr_valid_o), .instr_ready_i(instr_ready_i),
        .instr_data_o(instr_data_o), .instr_is32_o(instr_is32_o), .instr_addr_o(instr_addr_o)
    );

    // Memory image: a run of upper-half 32-bit instructions in one window,
    // hashed halfwords with a bias toward 32-bit openers elsewhere.
    function automatic logic [15:0] mem_hw(input logic [31:0] a);
        logic [31:0] h;
        if (a >= 32'h1000 && a < 32'h1100)
            return a[1] ? {5'b11111, 3'b000, a[7:0]} : (a[15:0] ^ 16'h0A5A);
        h = (a * 32'h9E37_79B1) ^ (a >> 5);
        h = h ^ (h >> 13);
        if (h[19:17] < 3'd3) return {5'b11101 + 5'(h[19:17]), h[10:0]};
        if (h[15:11] >= 5'b11101) return {1'b0, h[14:0]};
        return h[15:0];
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] w);
        return {mem_hw(w + 32'd2), mem_hw(w)};
    endfunction

    function automatic logic exp_wide(input logic [31:0] pc);
        logic [15:0] f;
        f = mem_hw(pc);
        return f[15:11] inside {5'b11101, 5'b11110, 5'b11111};
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] pc);
        return exp_wide(pc) ? {mem_hw(pc + 32'd2), mem_hw(pc)} : {16'h0000, mem_hw(pc)};
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // Fetch port model: queue accepted addresses, answer in order.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            rq.delete();
            rsp_valid_i <= 1'b0;
            rsp_data_i  <= '0;
        end else begin
            if (fetch_req_o && fetch_ack_i) rq.push_back(fetch_addr_o);
            if (rq.size() > 0 && (fixed_lat || $urandom_range(0, 3) != 0)) begin
                rsp_valid_i <= 1'b1;
                rsp_data_i  <= mem_word(rq.pop_front());
            end else begin
                rsp_valid_i <= 1'b0;
            end
        end
    end

    // Output monitor, sampled at the falling edge.
    logic [31:0] exp_pc = '0;
    logic [31:0] exp_faddr = '0;
    bit first_live = 1'b1;
    bit prev_flush = 1'b0;
    int last_run = -1;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rq.size() + int'(rsp_valid_i) <= 3, "R8 words in flight",
                  32'(rq.size() + int'(rsp_valid_i)), 32'd3);
            if (first_live) begin
                check(fetch_req_o && fetch_addr_o == 32'h0, "R9 first fetch after reset",
                      fetch_addr_o, 32'h0);
                first_live = 1'b0;
            end
            if (flush_i && fetch_req_o)
                check(1'b0, "R1 request during flush", 32'd1, 32'd0);
            if (fetch_req_o && fetch_ack_i) begin
                check(fetch_addr_o == exp_faddr && fetch_addr_o[1:0] == 2'b00,
                      "R1 fetch address", fetch_addr_o, exp_faddr);
                exp_faddr = exp_faddr + 32'd4;
            end
            if (prev_flush)
                check(!instr_valid_o, "R7 valid low after flush", 32'(instr_valid_o), 32'd0);
            if (flush_i) begin
                exp_pc    = {flush_addr_i[31:1], 1'b0};
                exp_faddr = {flush_addr_i[31:2], 2'b00};
                last_run  = -1;
            end else if (instr_valid_o && instr_ready_i) begin
                check(instr_addr_o == exp_pc, "R4 R7 instruction address", instr_addr_o, exp_pc);
                check(instr_is32_o == exp_wide(exp_pc), "R2 size flag",
                      32'(instr_is32_o), 32'(exp_wide(exp_pc)));
                if (exp_wide(exp_pc) && exp_pc[1])
                    check(instr_data_o == exp_data(exp_pc), "R5 joined 32-bit value",
                          instr_data_o, exp_data(exp_pc));
                else
                    check(instr_data_o == exp_data(exp_pc), "R3 instruction value",
                          instr_data_o, exp_data(exp_pc));
                if (run_chk && exp_pc >= RUN_BASE && exp_pc < RUN_END) begin
                    if (exp_pc != RUN_BASE)
                        check(cyc == last_run + 1, "R6 back-to-back delivery",
                              32'(cyc), 32'(last_run + 1));
                    last_run = cyc;
                end
                exp_pc = exp_pc + (exp_wide(exp_pc) ? 32'd4 : 32'd2);
            end
            prev_flush = flush_i;
        end
    end

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Stimulus: reset, random traffic, directed corners, more random traffic.
    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; flush_i = 1'b0; flush_addr_i = '0;
        fetch_ack_i = 1'b0; instr_ready_i = 1'b0;
        repeat (3) step();
        check(!instr_valid_o, "R9 valid low in reset", 32'(instr_valid_o), 32'd0);
        step();
        rst_n = 1'b1;

        for (int i = 0; i < 4000; i++) begin
            step();
            instr_ready_i = $urandom_range(0, 3) != 0;
            fetch_ack_i   = $urandom_range(0, 3) != 0;
            flush_i       = $urandom_range(0, 49) == 0;
            if (flush_i)
                flush_addr_i = {$urandom_range(0, 1023), 1'b0}
                               + (($urandom_range(0, 3) == 0) ? 32'h1000 : 32'h0);
        end

        // R7: two flushes in a row, the second one wins.
        step(); flush_i = 1'b1; flush_addr_i = 32'h0000_0206;
        step(); flush_i = 1'b1; flush_addr_i = 32'h0000_0312;
        step(); flush_i = 1'b0; instr_ready_i = 1'b1; fetch_ack_i = 1'b1;
        repeat (30) step();

        // R6: settle with a one-cycle fetch port, then enter the upper-half run.
        fixed_lat = 1'b1; instr_ready_i = 1'b0;
        repeat (10) step();
        flush_i = 1'b1; flush_addr_i = RUN_BASE; instr_ready_i = 1'b1; run_chk = 1'b1;
        step(); flush_i = 1'b0;
        repeat (60) step();
        run_chk = 1'b0; fixed_lat = 1'b0;

        for (int i = 0; i < 2000; i++) begin
            step();
            instr_ready_i = $urandom_range(0, 1) != 0;
            fetch_ack_i   = $urandom_range(0, 4) != 0;
            flush_i       = $urandom_range(0, 29) == 0;
            if (flush_i) flush_addr_i = {$urandom_range(0, 2047), $urandom_range(0, 1) == 1};
        end
        flush_i = 1'b0;
        repeat (5) step();
        finish_run();
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%h exp=%h", 32'(cyc), 32'd0);
        finish_run();
    end
endmodule